// File: doc/BRIEF.md
# Time-Binned Pulse Counter

This block counts rising edges on an unclocked external pulse line and reports the running total at a fixed time interval. The raw line is first brought into the system clock domain through a chain of flip-flops. A registered edge detector follows, and the counter advances in the system domain only. The counter is never cleared or gated while the block runs, and it wraps modulo 2^N.

A bin timer divides the system clock into equal bins; with the default 50 MHz clock and 50-cycle bins, each bin lasts 1 µs. On the last cycle of each bin, the block latches the count into a holding register. That value includes any edge detected in that same cycle. One cycle later the held value enters a 16-entry FIFO, which a downstream memory writer drains through a valid/ready handshake. If the FIFO is full when the held value arrives, the sample is dropped and a sticky flag records the loss.

Top module: `pulse_binner`

## Requirements
- R1: The count advances by exactly one for each low-to-high transition of `pulse_in`, wraps modulo 2^CNT_W, and never changes by more than one per clock. The input must stay high and low for at least two clock periods each.
- R2: A snapshot is taken every BIN_CYCLES clocks. The first is taken on the BIN_CYCLES-th clock edge after reset is released, and its entry becomes visible on `snap_valid` one clock later.
- R3: A transition first captured by the synchronizer at clock edge e is counted in the snapshot taken at edge s exactly when e <= s-2. No transition is counted twice or lost at a bin boundary.
- R4: Consecutive snapshots never decrease, apart from the modular wrap. The forward distance between two consecutive snapshots is at most BIN_CYCLES/4+1.
- R5: Snapshots leave the FIFO in the order in which they were taken, and the FIFO holds up to FIFO_DEPTH (16) entries.
- R6: A word moves out only on a clock edge where `snap_valid` and `snap_ready` are both high. While `snap_valid` is high and `snap_ready` is low, `snap_valid` stays high and `snap_data` holds its value.
- R7: A snapshot that reaches a full FIFO is discarded without disturbing the stored entries. `overflow` then rises on the next edge and stays high until reset.
- R8: While `rst_n` is low on a clock edge, the count, bin timer, synchronizer, FIFO and overflow flag are cleared. `snap_valid` and `overflow` read 0.
- R9: Pulse trains from one pulse per bin up to the limiting rate of one transition pair every four clocks are counted without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Raw external pulse line, asynchronous to clk |
| snap_valid | output | 1 | FIFO head holds a snapshot |
| snap_ready | input | 1 | Downstream accepts the head word |
| snap_data | output | CNT_W | Snapshot at the FIFO head |
| overflow | output | 1 | Sticky: a snapshot was dropped because the FIFO was full |

## Verification
The checker assumes that `pulse_in` is never high or low for fewer than two clocks. Under that assumption, a bin of BIN_CYCLES clocks contains at most BIN_CYCLES/4+1 edges, which gives the bound the monotonic-step property relies on. It also assumes that `snap_ready` may drop at any cycle without any protocol tie to `snap_valid`.

The stimulus changes `pulse_in` only at falling clock edges, with runs of at least two cycles. It forces a low gap of several cycles wherever the pulse pattern switches period, so that no clipped one-cycle pulse can occur. Expected snapshot values are computed from the edge index at which each transition is driven.

// File: rtl/pbin_pkg.sv
// Shared helpers for the time-binned pulse counter.
// Assumes: callers pass positive sizes.
package pbin_pkg;

    // Bits needed to hold any value from 0 to n, never fewer than one.
    function automatic int unsigned pbin_bits(input int unsigned n);
        int unsigned b;
        b = 1;
        while ((1 << b) <= n) b++;
        return b;
    endfunction

    // Bits needed to index n entries, never fewer than one.
    function automatic int unsigned pbin_idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : pbin_bits(n - 1);
    endfunction

endpackage

// File: rtl/pbin_sync_edge.sv
// Brings an asynchronous level into the clk domain through STAGES
// flip-flops. It then flags each low-to-high transition as a one-cycle
// pulse, using a registered copy of the synchronized level.
// Assumes: the input holds each level for at least two clk periods.
module pbin_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              level_d_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage (only for already-clean inputs).
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_chain
            // Shift the raw level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    // Keep last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d_q <= 1'b0;
        else        level_d_q <= chain_q[MSB];
    end

    // One-cycle flag when the synchronized level goes high.
    always_comb rise = chain_q[MSB] & ~level_d_q;

endmodule

// File: rtl/pbin_bin_timer.sv
// Divides clk into bins of BIN_CYCLES clocks. It raises `strobe` on the
// last cycle of each bin, then restarts from zero.
// Assumes: BIN_CYCLES >= 2.
module pbin_bin_timer
    import pbin_pkg::*;
#(
    parameter int unsigned BIN_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int unsigned TW = pbin_idx_bits(BIN_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(BIN_CYCLES - 1);

    logic [TW-1:0] tick_q;

    // Terminal-count decode of the bin timer.
    always_comb strobe = (tick_q == LAST);

    // Count clocks within the bin, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_q <= '0;
        else if (strobe) tick_q <= '0;
        else             tick_q <= tick_q + 1'b1;
    end

endmodule

// File: rtl/pbin_counter.sv
// Free-running modulo-2^W edge counter. It also exposes the value the
// counter will hold after this edge, so that a same-cycle edge is visible.
// Assumes: inc is a single-cycle flag.
module pbin_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx
);
    // Next count, including this cycle's edge.
    always_comb cnt_nx = cnt_q + {{(W-1){1'b0}}, inc};

    // Register the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/pbin_fifo.sv
// Synchronous FIFO with a valid/ready read side. A push while full is
// refused, and the stored entries are left untouched. The head word is
// shown combinationally from storage.
// Assumes: DEPTH >= 2.
module pbin_fifo
    import pbin_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [W-1:0]                      push_data,
    output logic                              full,
    output logic [pbin_bits(DEPTH)-1:0]       level,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [W-1:0]                      out_data
);
    localparam int unsigned AW = pbin_idx_bits(DEPTH);
    localparam int unsigned LW = pbin_bits(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    logic [W-1:0]  store_q [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [LW-1:0] level_q;
    logic          do_push;
    logic          do_pop;

    // Status and handshake decode.
    always_comb begin
        full      = (level_q == LVL_FULL);
        out_valid = (level_q != '0);
        do_push   = push & ~full;
        do_pop    = out_valid & out_ready;
        level     = level_q;
        out_data  = store_q[rd_ptr_q];
    end

    // Write accepted words into storage.
    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_ptr_q] <= push_data;
    end

    // Advance the write pointer with an explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr_q <= '0;
        else if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end

    // Advance the read pointer with an explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr_q <= '0;
        else if (do_pop) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else if (do_push && !do_pop) level_q <= level_q + 1'b1;
        else if (!do_push && do_pop) level_q <= level_q - 1'b1;
    end

endmodule

// File: rtl/pulse_binner.sv
// Top level of the time-binned pulse counter. It synchronizes the raw pulse
// line, counts its rising edges, and latches the count at the end of every
// bin. The latched value is queued into a FIFO for a downstream writer.
// Assumes: pulse_in high/low times of at least two clk periods, and
// BIN_CYCLES >= 2.
module pulse_binner
    import pbin_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned BIN_CYCLES  = 50,
    parameter int unsigned FIFO_DEPTH  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    output logic             snap_valid,
    input  logic             snap_ready,
    output logic [CNT_W-1:0] snap_data,
    output logic             overflow
);
    localparam int unsigned LVL_W = pbin_bits(FIFO_DEPTH);

    logic             rise;
    logic             strobe;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             hold_vld;
    logic [CNT_W-1:0] hold_data;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             ovf_q;

    pbin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise     (rise)
    );

    pbin_bin_timer #(.BIN_CYCLES(BIN_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    pbin_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (rise),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    // Latch the count, including a same-cycle edge, at the end of each bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
        end else begin
            hold_vld <= strobe;
            if (strobe) hold_data <= cnt_nx;
        end
    end

    pbin_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (hold_vld),
        .push_data (hold_data),
        .full      (fifo_full),
        .level     (fifo_level),
        .out_valid (snap_valid),
        .out_ready (snap_ready),
        .out_data  (snap_data)
    );

    // Set the sticky flag when a held sample meets a full FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (hold_vld && fifo_full) ovf_q <= 1'b1;
    end

    always_comb overflow = ovf_q;

endmodule

// File: rtl/pulse_binner_chk.sv
// Property checker for pulse_binner, attached through bind.
// Assumes: the pulse input obeys the two-clock minimum high/low time.
module pulse_binner_chk #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned BIN_CYCLES = 50,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned LVL_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             strobe,
    input logic             hold_vld,
    input logic [CNT_W-1:0] hold_data,
    input logic             fifo_full,
    input logic [LVL_W-1:0] fifo_level,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] out_data,
    input logic             overflow
);
    localparam int unsigned MAX_STEP = BIN_CYCLES / 4 + 1;

    int unsigned      gap_q;
    logic [CNT_W-1:0] last_q;
    logic             have_last_q;
    logic [CNT_W-1:0] step;

    // Count clocks since reset or since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      gap_q <= 0;
        else if (strobe) gap_q <= 0;
        else             gap_q <= gap_q + 1;
    end

    // Remember the previous held snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q      <= '0;
            have_last_q <= 1'b0;
        end else if (hold_vld) begin
            last_q      <= hold_data;
            have_last_q <= 1'b1;
        end
    end

    always_comb step = hold_data - last_q;

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_bin_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (gap_q == BIN_CYCLES - 1));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    p_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && have_last_q) |-> (step <= CNT_W'(MAX_STEP)));

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_DEPTH));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && fifo_full) |=> overflow);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow);

    p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !out_ready) |=> (fifo_level == $past(fifo_level)));

endmodule

bind pulse_binner pulse_binner_chk #(
    .CNT_W      (CNT_W),
    .BIN_CYCLES (BIN_CYCLES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_q),
    .strobe     (strobe),
    .hold_vld   (hold_vld),
    .hold_data  (hold_data),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level),
    .out_valid  (snap_valid),
    .out_ready  (snap_ready),
    .out_data   (snap_data),
    .overflow   (overflow)
);

// File: tb/sim_pulse_binner.sv
// Self-checking bench. It drives several pulse trains and computes each
// expected snapshot from the edge index at which every rise was driven.
module sim_pulse_binner;
    localparam int CNT_W  = 8;
    localparam int BIN    = 50;
    localparam int STEPS  = 4620;
    localparam int N_EXP  = 78;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             snap_ready = 1'b0;
    logic             snap_valid;
    logic [CNT_W-1:0] snap_data;
    logic             overflow;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int rise_e [0:1023];
    int n_rise  = 0;
    int n_got   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pulse_binner u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_in   (pulse_in),
        .snap_valid (snap_valid),
        .snap_ready (snap_ready),
        .snap_data  (snap_data),
        .overflow   (overflow)
    );

    // Edge index since reset release (edge 1 is the first active edge).
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Pulse level to present for clock edge n.
    function automatic logic level_at(input int n);
        int m;
        m = n % 1000;
        if (n >= 4500 || m >= 995 || m < 3) return 1'b0;
        if (n < 1000)  return ((n + 1) % 50) < 25;
        if (n < 2000)  return (n % 25) < 12;
        if (n < 3000)  return (n % 4) < 2;
        return (n % 6) < 3;
    endfunction

    // Expected snapshot for bin k: rises captured at edge <= 50k-2.
    function automatic logic [CNT_W-1:0] exp_snap(input int k);
        int c;
        c = 0;
        for (int i = 0; i < n_rise; i++)
            if (rise_e[i] <= BIN * k - 2) c++;
        return CNT_W'(c);
    endfunction

    // Bin index of the idx-th word expected at the output.
    function automatic int exp_bin(input int idx);
        return (idx < 56) ? idx + 1 : idx - 56 + 71;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(snap_valid == 1'b0, "R8 valid in reset", int'(snap_valid), 0);
        check(overflow == 1'b0, "R8 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        for (int i = 0; i < STEPS; i++) begin
            int c;
            logic lvl;
            @(negedge clk);
            c   = cyc;
            lvl = level_at(c + 1);
            if (lvl && !pulse_in) begin
                rise_e[n_rise] = c + 1;
                n_rise++;
            end
            pulse_in   = lvl;
            snap_ready = !(c >= 2010 && c < 3510);
            if (c == 50) check(snap_valid == 1'b0, "R2 no entry before first bin", int'(snap_valid), 0);
            if (c == 51) check(snap_valid == 1'b1, "R2 first entry after one bin", int'(snap_valid), 1);
            if (c == 2840) check(overflow == 1'b0, "R7 no overflow before drop", int'(overflow), 0);
            if (c == 2860) check(overflow == 1'b1, "R7 overflow after drop", int'(overflow), 1);
            if (snap_valid && snap_ready) begin
                if (n_got < N_EXP) begin
                    int k;
                    logic [CNT_W-1:0] e;
                    k = exp_bin(n_got);
                    e = exp_snap(k);
                    // R1 R3 R4 R5 R9: exact value and order of every snapshot
                    check(snap_data == e, "R3/R5 snapshot value", int'(snap_data), int'(e));
                end else begin
                    check(1'b0, "R5 extra output word", n_got, N_EXP);
                end
                n_got++;
            end
        end
        check(n_got == N_EXP, "R7 words delivered after drops", n_got, N_EXP);
        check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        check(n_rise > 256, "R1 stimulus wraps counter", n_rise, 257);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule